// File: doc/BRIEF.md
# Threshold-Sensor SPI Register Slave

This block is the digital register front end of a 32-channel discrete threshold sensor. It sits behind an SPI bus in mode 0. The analog comparators are outside the block: their 32 results arrive on an input port. A host reads those results and programs per-bank sensing modes and threshold settings. The first byte of every transaction is a command byte. Bit 7 selects a read (1) or a write (0), and bits 6:0 give the register address. The bytes after the command carry the data, most significant byte first.

SCLK, CS and MOSI pass through a short synchronizer into the system clock domain, where edges are detected. The system clock must run at least eight times faster than SCLK. The first byte of a read is loaded into a shift register at the last command bit. MISO then advances on each falling SCLK edge. The master decides how many bytes it clocks: one, two or four, and any further bytes read as zero.

The threshold registers cannot accept an odd hysteresis value. A write that carries one drives the block into a locked state. In that state it reads back zeros and ignores every write until a hardware reset. A soft-reset bit in the control register clears the programmable settings. A test-mode bit substitutes a programmable pattern for the comparator results.

Top module: `thr_sense_spi`

## Requirements
- R1: A command byte with bit 7 = 1 starts a read of the address in bits 6:0. Read data leaves on MISO most significant bit first and changes only after falling SCLK edges. MISO stays 0 while CS is deasserted.
- R2: The status bytes at 0x10, 0x12, 0x14 and 0x16 return channels 7..0, 15..8, 23..16 and 31..24. Bit i of a status byte is the lowest channel of that group plus i.
- R3: Address 0x78 returns all 32 channel results as one word, channels 31..24 in the first byte. A master that clocks only one byte receives that first byte.
- R4: The control register at 0x02 holds test mode in bit 0 and soft reset in bit 1. Both bits read back, and bits 7:2 read 0.
- R5: The sense-select register at 0x04 stores bits 3:0, one mode bit per bank of eight channels (0 ground-open, 1 supply-open). Bits 7:4 read 0.
- R6: The ground-open threshold at 0x3A and the supply-open threshold at 0x3C are 16-bit registers. The hysteresis is the high byte, sent first, and the center is the low byte. They read back as two bytes. A write that ends after one data byte leaves the register unchanged.
- R7: A threshold write whose high byte is odd (bit 0 = 1) is not stored and locks the block. While locked, every read returns 0x00 and all writes, including soft reset, are ignored. Only the hardware reset clears the lock.
- R8: While soft reset (control bit 1) is set, the sense-select, threshold and test-pattern registers are held at 0 and writes to them are lost. They stay 0 after the bit is cleared.
- R9: With test mode (control bit 0) set, every status byte and the status word return the byte held at 0x1E in place of the comparator results.
- R10: Writes to unimplemented addresses change nothing, and reads from them return 0x00.
- R11: Raising CS before the eighth bit of a byte aborts the transaction without changing any register.
- R12: After hardware reset, all registers read 0 and MISO is 0. Bytes clocked beyond a register's width read 0, and surplus write bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from master |
| comp_in | input | 32 | Comparator results, one bit per channel |
| miso | output | 1 | SPI data to master |

## Verification
The assertions take for granted that SCLK is low whenever CS changes, as mode 0 requires. They also assume each SCLK level lasts several system clocks, so that every synchronized edge is seen as one pulse. The bench drives every SCLK phase for eight system clocks. It moves CS only while SCLK is low and waits several clocks around each CS change. The comparator input is changed only between transactions.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam logic [6:0] A_CTRL   = 7'h02;
  localparam logic [6:0] A_SENSE  = 7'h04;
  localparam logic [6:0] A_STBASE = 7'h10;
  localparam logic [6:0] A_TPAT   = 7'h1E;
  localparam logic [6:0] A_THR_G  = 7'h3A;
  localparam logic [6:0] A_THR_S  = 7'h3C;
  localparam logic [6:0] A_WORD   = 7'h78;
  localparam int CTRL_TEST = 0;
  localparam int CTRL_SRST = 1;
endpackage

// File: rtl/tss_sync_edge.sv
module tss_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam int TOP = STAGES - 1;
  logic [TOP:0] sclk_p, cs_p, mosi_p;
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[TOP-1:0], sclk};
      cs_p   <= {cs_p[TOP-1:0], cs_n};
      mosi_p <= {mosi_p[TOP-1:0], mosi};
      sclk_d <= sclk_p[TOP];
    end
  end

  assign sclk_rise = sclk_p[TOP] & ~sclk_d;
  assign sclk_fall = ~sclk_p[TOP] & sclk_d;
  assign cs_act    = ~cs_p[TOP];
  assign mosi_s    = mosi_p[TOP];
endmodule

// File: rtl/tss_frame.sv
module tss_frame (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_rise,
  input  logic       cs_act,
  input  logic       mosi_s,
  output logic       byte_done,
  output logic [7:0] byte_data,
  output logic [1:0] byte_idx
);
  logic [6:0] sh;
  logic [2:0] bit_cnt;
  logic [1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      sh        <= '0;
      bit_cnt   <= '0;
      idx_q     <= '0;
      byte_done <= 1'b0;
      byte_data <= '0;
      byte_idx  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sclk_rise) begin
        sh      <= {sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          byte_data <= {sh, mosi_s};
          byte_idx  <= idx_q;
          if (idx_q != 2'd3) idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

  // R11
  bitcnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (bit_cnt == 3'd0 && !byte_done));
endmodule

// File: rtl/tss_regs.sv
module tss_regs
  import tss_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [1:0]        byte_idx,
  input  logic [7:0]        byte_data,
  input  logic [NUM_CH-1:0] comp_in,
  output logic              rd_load,
  output logic [NUM_CH-1:0] rd_word
);
  localparam int NB = NUM_CH / 8;

  logic [7:0]        cmd_q, hi_q, tpat_q;
  logic [1:0]        ctrl_q;
  logic [NB-1:0]     sense_q;
  logic [15:0]       thr_g_q, thr_s_q;
  logic              locked_q;
  logic [NUM_CH-1:0] comp_q, stat_v;
  logic [6:0]        waddr, raddr;

  assign waddr  = cmd_q[6:0];
  assign raddr  = byte_data[6:0];
  assign stat_v = ctrl_q[CTRL_TEST] ? {NB{tpat_q}} : comp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; hi_q <= '0; tpat_q <= '0; ctrl_q <= '0;
      sense_q <= '0; thr_g_q <= '0; thr_s_q <= '0;
      locked_q <= 1'b0; comp_q <= '0;
    end else begin
      comp_q <= comp_in;
      if (byte_done && !locked_q) begin
        if (byte_idx == 2'd0) begin
          cmd_q <= byte_data;
        end else if (!cmd_q[7] && byte_idx == 2'd1) begin
          case (waddr)
            A_CTRL:           ctrl_q  <= byte_data[1:0];
            A_SENSE:          sense_q <= byte_data[NB-1:0];
            A_TPAT:           tpat_q  <= byte_data;
            A_THR_G, A_THR_S: hi_q    <= byte_data;
            default: ;
          endcase
        end else if (!cmd_q[7] && byte_idx == 2'd2) begin
          if (waddr == A_THR_G || waddr == A_THR_S) begin
            if (hi_q[0]) locked_q <= 1'b1;
            else if (waddr == A_THR_G) thr_g_q <= {hi_q, byte_data};
            else thr_s_q <= {hi_q, byte_data};
          end
        end
      end
      if (ctrl_q[CTRL_SRST]) begin
        sense_q <= '0; tpat_q <= '0; thr_g_q <= '0; thr_s_q <= '0;
      end
    end
  end

  assign rd_load = byte_done && byte_idx == 2'd0 && byte_data[7];

  always_comb begin
    rd_word = '0;
    if (!locked_q) begin
      case (raddr)
        A_CTRL:  rd_word[NUM_CH-1 -: 8]  = {6'b0, ctrl_q};
        A_SENSE: rd_word[NUM_CH-1 -: 8]  = 8'(sense_q);
        A_TPAT:  rd_word[NUM_CH-1 -: 8]  = tpat_q;
        A_THR_G: rd_word[NUM_CH-1 -: 16] = thr_g_q;
        A_THR_S: rd_word[NUM_CH-1 -: 16] = thr_s_q;
        A_WORD:  rd_word = stat_v;
        default: begin
          for (int k = 0; k < NB; k++)
            if (raddr == A_STBASE + 7'(2 * k))
              rd_word[NUM_CH-1 -: 8] = stat_v[8*k +: 8];
        end
      endcase
    end
  end

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);
  // R7
  lock_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> ($stable(thr_g_q) && $stable(thr_s_q) && $stable(sense_q) && $stable(ctrl_q)));
  // R8
  srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTRL_SRST] |=> (sense_q == '0 && tpat_q == '0 && thr_g_q == '0 && thr_s_q == '0));
  // R6
  thr_even_chk: assert property (@(posedge clk) disable iff (rst)
    !thr_g_q[8] && !thr_s_q[8]);
endmodule

// File: rtl/thr_sense_spi.sv
module thr_sense_spi #(
  parameter int NUM_CH      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [NUM_CH-1:0] comp_in,
  output logic              miso
);
  logic sclk_rise, sclk_fall, cs_act, mosi_s;
  logic byte_done, rd_load, rd_phase;
  logic [7:0] byte_data;
  logic [1:0] byte_idx;
  logic [NUM_CH-1:0] rd_word, shreg;

  tss_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s));

  tss_frame u_frame (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .cs_act(cs_act), .mosi_s(mosi_s),
    .byte_done(byte_done), .byte_data(byte_data), .byte_idx(byte_idx));

  tss_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .byte_done(byte_done), .byte_idx(byte_idx),
    .byte_data(byte_data), .comp_in(comp_in), .rd_load(rd_load), .rd_word(rd_word));

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      shreg    <= '0;
      rd_phase <= 1'b0;
      miso     <= 1'b0;
    end else if (rd_load) begin
      shreg    <= rd_word;
      rd_phase <= 1'b1;
    end else if (sclk_fall) begin
      miso  <= rd_phase & shreg[NUM_CH-1];
      shreg <= shreg << 1;
    end
  end

  // R1
  idle_miso_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso);
  // R1
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !sclk_fall) |=> $stable(miso));
endmodule

// File: tb/thr_sense_spi_tb.sv
module thr_sense_spi_tb;
  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [31:0] comp = 32'h0;
  logic miso;
  int checks = 0, failures = 0, idle_cnt = 0;

  // Reference model state
  logic [7:0] m_ctrl, m_sense, m_tpat;
  logic [15:0] m_thr [2];
  bit m_lock;

  thr_sense_spi u_dut (.clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
                       .comp_in(comp), .miso(miso));

  always #4 clk = ~clk;

  function automatic void m_reset();
    m_ctrl = 0; m_sense = 0; m_tpat = 0; m_thr[0] = 0; m_thr[1] = 0; m_lock = 0;
  endfunction

  function automatic logic [31:0] m_status();
    return m_ctrl[0] ? {4{m_tpat}} : comp;
  endfunction

  function automatic logic [39:0] m_read(input logic [6:0] a);
    logic [31:0] st = m_status();
    if (m_lock) return 40'h0;
    case (a)
      7'h02: return {m_ctrl, 32'h0};
      7'h04: return {m_sense, 32'h0};
      7'h1E: return {m_tpat, 32'h0};
      7'h10: return {st[7:0], 32'h0};
      7'h12: return {st[15:8], 32'h0};
      7'h14: return {st[23:16], 32'h0};
      7'h16: return {st[31:24], 32'h0};
      7'h3A: return {m_thr[0], 24'h0};
      7'h3C: return {m_thr[1], 24'h0};
      7'h78: return {st, 8'h0};
      default: return 40'h0;
    endcase
  endfunction

  function automatic void m_write(input logic [6:0] a, input logic [31:0] w, input int nd);
    if (m_lock) return;
    case (a)
      7'h02: if (nd >= 1) m_ctrl = w[31:24] & 8'h03;
      7'h04: if (nd >= 1) m_sense = w[31:24] & 8'h0F;
      7'h1E: if (nd >= 1) m_tpat = w[31:24];
      7'h3A, 7'h3C: if (nd >= 2) begin
        if (w[24]) m_lock = 1;
        else m_thr[a == 7'h3C] = w[31:16];
      end
      default: ;
    endcase
    if (m_ctrl[1]) begin m_sense = 0; m_tpat = 0; m_thr[0] = 0; m_thr[1] = 0; end
  endfunction

  task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = 8'h0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      repeat (8) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input logic rd, input logic [6:0] a, input logic [31:0] w,
                     input int nd, input int abort_bits, input string tag);
    logic [39:0] exp;
    logic [7:0] rb;
    exp = m_read(a);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    send_bits({rd, a}, 8, rb);
    for (int j = 0; j < nd; j++) begin
      send_bits(rd ? 8'h00 : w[31 - 8*j -: 8], 8, rb);
      if (rd) begin
        checks++;
        if (rb !== exp[39 - 8*j -: 8]) begin
          failures++;
          $display("FAIL %s addr=%h byte%0d actual=%h expected=%h", tag, a, j, rb, exp[39 - 8*j -: 8]);
        end
      end
    end
    if (abort_bits > 0) send_bits(8'hFF, abort_bits, rb);
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (16) @(negedge clk);
    if (!rd) m_write(a, w, nd);
  endtask

  task automatic rd(input logic [6:0] a, input int nd, input string tag);
    txn(1'b1, a, 32'h0, nd, 0, tag);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] w, input int nd);
    txn(1'b0, a, w, nd, 0, "wr");
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    m_reset();
    repeat (4) @(negedge clk);
  endtask

  // R1: MISO low whenever deselected, compared every clock
  always @(posedge clk) idle_cnt <= cs_n ? idle_cnt + 1 : 0;
  always @(negedge clk) begin
    if (!rst && idle_cnt >= 6) begin
      checks++;
      if (miso !== 1'b0) begin
        failures++;
        $display("FAIL R1 idle miso actual=%b expected=0", miso);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    hw_reset();
    // R12 reset state
    rd(7'h02, 1, "R12"); rd(7'h04, 1, "R12"); rd(7'h1E, 1, "R12");
    rd(7'h3A, 2, "R12"); rd(7'h3C, 2, "R12");
    // R2, R3 status reads
    comp = 32'hA5C3_1E77; repeat (4) @(negedge clk);
    rd(7'h10, 1, "R2"); rd(7'h12, 1, "R2"); rd(7'h14, 1, "R2"); rd(7'h16, 1, "R2");
    rd(7'h78, 4, "R3"); rd(7'h78, 1, "R3"); rd(7'h78, 5, "R12");
    comp = 32'h0F1E_2D3C; repeat (4) @(negedge clk);
    rd(7'h78, 4, "R3"); rd(7'h12, 2, "R2");
    // R5 sense select
    wr(7'h04, 32'hFF00_0000, 1); rd(7'h04, 1, "R5");
    wr(7'h04, 32'h0600_0000, 1); rd(7'h04, 1, "R5");
    // R6 thresholds
    wr(7'h3A, 32'h0410_0000, 2); rd(7'h3A, 2, "R6");
    wr(7'h3C, 32'h0206_0000, 2); rd(7'h3C, 3, "R6");
    wr(7'h3A, 32'h0800_0000, 1); rd(7'h3A, 2, "R6");
    // R12 surplus write bytes
    wr(7'h04, 32'h0901_0203, 3); rd(7'h04, 1, "R12");
    // R11 abort mid-byte
    txn(1'b0, 7'h04, 32'h0, 0, 5, "R11"); rd(7'h04, 1, "R11");
    txn(1'b0, 7'h3C, 32'h0A00_0000, 1, 6, "R11"); rd(7'h3C, 2, "R11");
    // R9 test mode
    wr(7'h1E, 32'h5A00_0000, 1); rd(7'h1E, 1, "R9");
    wr(7'h02, 32'h0100_0000, 1); rd(7'h02, 1, "R4");
    rd(7'h10, 1, "R9"); rd(7'h16, 1, "R9"); rd(7'h78, 4, "R9");
    wr(7'h02, 32'h0000_0000, 1); rd(7'h78, 4, "R9");
    // R10 unimplemented
    wr(7'h20, 32'hFF00_0000, 1); rd(7'h20, 1, "R10"); rd(7'h7F, 2, "R10");
    rd(7'h04, 1, "R10");
    // R8 soft reset
    wr(7'h02, 32'hFE00_0000, 1); rd(7'h02, 1, "R4");
    rd(7'h04, 1, "R8"); rd(7'h3A, 2, "R8"); rd(7'h1E, 1, "R8");
    wr(7'h04, 32'h0300_0000, 1); rd(7'h04, 1, "R8");
    wr(7'h02, 32'h0000_0000, 1); rd(7'h04, 1, "R8"); rd(7'h3C, 2, "R8");
    // R7 lock-up
    wr(7'h3A, 32'h0612_0000, 2); wr(7'h04, 32'h0500_0000, 1);
    rd(7'h3A, 2, "R7");
    wr(7'h3C, 32'h0320_0000, 2);
    rd(7'h3A, 2, "R7"); rd(7'h04, 1, "R7"); rd(7'h78, 4, "R7");
    wr(7'h04, 32'h0F00_0000, 1); wr(7'h02, 32'h0200_0000, 1); wr(7'h02, 32'h0000_0000, 1);
    rd(7'h04, 1, "R7"); rd(7'h02, 1, "R7");
    hw_reset();
    rd(7'h3A, 2, "R7"); rd(7'h78, 4, "R7");
    wr(7'h04, 32'h0C00_0000, 1); rd(7'h04, 1, "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule